// File: doc/BRIEF.md
# Translation-Unit Performance Counter Bank

This block is a bank of hardware performance counters that sits beside an address-translation unit. Slot 0 is a free-running cycle counter. Slots 1 to NUM_EVT are event counters, and each one is steered by a 64-bit selector register. A selector chooses one event code and can narrow counting to strobes whose process or device context matches. A per-slot inhibit mask stops chosen counters, and a sticky per-slot overflow status word drives one level interrupt.

The translation logic reports activity on NUM_SRC strobe lanes. Each lane carries an event code, a process-context tag, a device-context tag and an ID-type bit. In one clock an event counter advances by the number of lanes that match its selector, so simultaneous events are never lost. Software programs the bank over a simple 64-bit write port and reads it through a combinational read port. The counter value is CTR_W bits wide, with CTR_W between 32 and 62.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every counter, every selector and the overflow status word read zero, `ovf_irq` is low, and the inhibit word reads all ones over the NUM_EVT+1 implemented bits, so no counter moves.
- R2: Byte addresses (8-byte aligned): counter n at 0x068+8n; the selector of event counter n (n at least 1) at 0x160+8(n-1); inhibit word at 0x058; overflow status at 0x060. Any other address reads zero.
- R3: While inhibit bit 0 is clear, the cycle counter rises by one every clock. Bit 63 of its register is its overflow flag, which can be both written and read.
- R4: Selector bits 14:0 hold the event code. While inhibit bit n is clear, event counter n rises each clock by the number of valid lanes whose code equals that field and whose filters pass. A code of 0 never counts.
- R5: Selector bit 60 turns on the process filter: the lane tag must equal selector bits 35:16. When bit 60 or bit 61 is set, the lane's ID-type bit must also equal selector bit 62. With both filters off, the tags and the type are ignored.
- R6: Selector bit 61 turns on the device filter: the lane tag must equal selector bits 59:36. When selector bit 15 is also set, the bits of the device field from bit 0 up to and including its lowest zero bit are not compared.
- R7: A set inhibit bit n freezes counter n. The inhibit word can be written, and bits above NUM_EVT read zero.
- R8: A counter write keeps the low CTR_W bits. Counter bits CTR_W to 62 read zero, and bit 63 reads zero for event counters.
- R9: A counter that passes all ones wraps modulo 2^CTR_W and sets its overflow flag. For event counters that flag is selector bit 63, which a selector write also sets or clears.
- R10: A wrap while the slot's flag is clear sets status bit n. Status bits stay set until software writes a 1 to them. `ovf_irq` is high whenever any status bit is set.
- R11: A wrap while the slot's flag is already set leaves the status bit and `ovf_irq` unchanged. Clearing the flag re-arms the slot.
- R12: When a counter write and an increment fall in the same clock, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| evt_valid | input | NUM_SRC | Strobe valid, one per lane |
| evt_id | input | NUM_SRC*15 | Event code per lane |
| evt_pid | input | NUM_SRC*20 | Process-context tag per lane |
| evt_did | input | NUM_SRC*24 | Device-context tag per lane |
| evt_idtype | input | NUM_SRC | ID-type bit per lane |
| ovf_irq | output | 1 | Overflow interrupt, level |

## Verification
The matching logic is driven from a table of lane patterns, each sent into a cleared counter. Some patterns differ only in event code, which separates the code compare from the filters. Others differ by one tag bit or only in the type bit, which shows that each filter, and the type check, gates counting on its own. A device-tag pair that differs only below the lowest zero bit of the programmed field is sent with partial match both on and off, and the two results must differ. Two lanes that hit in the same clock must add two, and counters preset near all ones show the gap between a wrap with the flag clear, which raises the interrupt, and a wrap with the flag set, which stays silent.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int EVT_W = 15;
  localparam int PID_W = 20;
  localparam int DID_W = 24;
  localparam int SEL_W = 63;           // selector bits held apart from the flag
  localparam int PM_BIT = 15;
  localparam int PID_LSB = 16;
  localparam int DID_LSB = 36;
  localparam int PV_BIT = 60;
  localparam int DV_BIT = 61;
  localparam int IDT_BIT = 62;
  localparam int FLAG_BIT = 63;

  // Device-tag bits that take part in the compare; with partial match on,
  // everything up to and including the lowest zero bit is a don't-care.
  function automatic logic [DID_W-1:0] did_care_mask(input logic [DID_W-1:0] v,
                                                      input logic partial);
    if (partial) return ~(v ^ (v + DID_W'(1)));
    return '1;
  endfunction

  function automatic logic strobe_hits(input logic [SEL_W-1:0] sel,
                                       input logic [EVT_W-1:0] id,
                                       input logic [PID_W-1:0] pid,
                                       input logic [DID_W-1:0] did,
                                       input logic typ);
    logic [EVT_W-1:0] code;
    logic [PID_W-1:0] spid;
    logic [DID_W-1:0] sdid;
    logic id_ok, pid_ok, did_ok, typ_ok;
    code   = sel[EVT_W-1:0];
    spid   = sel[PID_LSB +: PID_W];
    sdid   = sel[DID_LSB +: DID_W];
    id_ok  = (code != '0) && (code == id);
    pid_ok = !sel[PV_BIT] || (pid == spid);
    did_ok = !sel[DV_BIT] || (((did ^ sdid) & did_care_mask(sdid, sel[PM_BIT])) == '0);
    typ_ok = !(sel[PV_BIT] || sel[DV_BIT]) || (typ == sel[IDT_BIT]);
    return id_ok && pid_ok && did_ok && typ_ok;
  endfunction
endpackage

// File: rtl/perf_match.sv
module perf_match
  import perf_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int INC_W = 2
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [NUM_SRC-1:0]       evt_valid,
  input  logic [NUM_SRC*EVT_W-1:0] evt_id,
  input  logic [NUM_SRC*PID_W-1:0] evt_pid,
  input  logic [NUM_SRC*DID_W-1:0] evt_did,
  input  logic [NUM_SRC-1:0]       evt_idtype,
  output logic [INC_W-1:0]         inc
);
  logic [NUM_SRC-1:0] hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lane
    assign hit[s] = evt_valid[s] &&
                    strobe_hits(sel, evt_id[s*EVT_W +: EVT_W], evt_pid[s*PID_W +: PID_W],
                                evt_did[s*DID_W +: DID_W], evt_idtype[s]);
  end

  always_comb begin
    inc = '0;
    for (int s = 0; s < NUM_SRC; s++) inc = inc + INC_W'(hit[s]);
  end
endmodule

// File: rtl/perf_slot.sv
module perf_slot #(
  parameter int CTR_W = 40,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [INC_W-1:0] inc,
  input  logic             cnt_wr,
  input  logic [CTR_W-1:0] cnt_wdata,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic [CTR_W-1:0] count,
  output logic             flag,
  output logic             raise
);
  logic [CTR_W:0] sum;
  logic           wrap;

  assign sum   = {1'b0, count} + (CTR_W+1)'(inc);
  assign wrap  = run && !cnt_wr && sum[CTR_W];
  assign raise = wrap && !flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      flag  <= 1'b0;
    end else begin
      if (cnt_wr)   count <= cnt_wdata;
      else if (run) count <= sum[CTR_W-1:0];
      if (flag_wr)   flag <= flag_wdata;
      else if (wrap) flag <= 1'b1;
    end
  end

  AST_INHIBIT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count)); // R7
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !flag_wr) |=> flag); // R9
  AST_WRAP_GOES_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count < $past(count))); // R9
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_pkg::*;
#(
  parameter int NUM_EVT = 7,
  parameter int CTR_W = 40,
  parameter int NUM_SRC = 2,
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [63:0]              reg_wdata,
  output logic [63:0]              reg_rdata,
  input  logic [NUM_SRC-1:0]       evt_valid,
  input  logic [NUM_SRC*EVT_W-1:0] evt_id,
  input  logic [NUM_SRC*PID_W-1:0] evt_pid,
  input  logic [NUM_SRC*DID_W-1:0] evt_did,
  input  logic [NUM_SRC-1:0]       evt_idtype,
  output logic                     ovf_irq
);
  localparam int NUM_CTR  = NUM_EVT + 1;
  localparam int INC_W    = $clog2(NUM_SRC + 1);
  localparam int CTR_BASE = 'h068;
  localparam int SEL_BASE = 'h160;
  localparam int INH_OFS  = 'h058;
  localparam int OVF_OFS  = 'h060;

  function automatic logic [ADDR_W-1:0] ctr_addr(input int n);
    return ADDR_W'(CTR_BASE + 8 * n);
  endfunction

  function automatic logic [ADDR_W-1:0] sel_addr(input int n);
    return ADDR_W'(SEL_BASE + 8 * (n - 1));
  endfunction

  logic [NUM_CTR-1:0] inhibit_q;
  logic [NUM_CTR-1:0] ovf_q;
  logic [NUM_CTR-1:0] ovf_clr;
  logic [NUM_CTR-1:0] raise_v;
  logic [NUM_CTR-1:0] flag_v;
  logic [NUM_CTR-1:0] wr_ctr;
  logic [NUM_EVT-1:0] wr_sel;
  logic               wr_inh;
  logic               wr_ovf;
  logic [SEL_W-1:0]   sel_q [NUM_EVT];
  logic [CTR_W-1:0]   cnt   [NUM_CTR];

  assign wr_inh  = reg_wr_en && (reg_addr == ADDR_W'(INH_OFS));
  assign wr_ovf  = reg_wr_en && (reg_addr == ADDR_W'(OVF_OFS));
  assign ovf_clr = wr_ovf ? reg_wdata[NUM_CTR-1:0] : '0;
  assign ovf_irq = |ovf_q;

  // Cycle counter: no selector, flag kept with the count
  assign wr_ctr[0] = reg_wr_en && (reg_addr == ctr_addr(0));

  perf_slot #(.CTR_W(CTR_W), .INC_W(INC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .run(!inhibit_q[0]), .inc(INC_W'(1)),
    .cnt_wr(wr_ctr[0]), .cnt_wdata(reg_wdata[CTR_W-1:0]),
    .flag_wr(wr_ctr[0]), .flag_wdata(reg_wdata[FLAG_BIT]),
    .count(cnt[0]), .flag(flag_v[0]), .raise(raise_v[0])
  );

  // Event counters: flag lives in the selector's top bit
  for (genvar g = 1; g < NUM_CTR; g++) begin : g_evt
    logic [INC_W-1:0] inc;

    assign wr_ctr[g]   = reg_wr_en && (reg_addr == ctr_addr(g));
    assign wr_sel[g-1] = reg_wr_en && (reg_addr == sel_addr(g));

    perf_match #(.NUM_SRC(NUM_SRC), .INC_W(INC_W)) u_match (
      .sel(sel_q[g-1]), .evt_valid(evt_valid), .evt_id(evt_id), .evt_pid(evt_pid),
      .evt_did(evt_did), .evt_idtype(evt_idtype), .inc(inc)
    );

    perf_slot #(.CTR_W(CTR_W), .INC_W(INC_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .run(!inhibit_q[g]), .inc(inc),
      .cnt_wr(wr_ctr[g]), .cnt_wdata(reg_wdata[CTR_W-1:0]),
      .flag_wr(wr_sel[g-1]), .flag_wdata(reg_wdata[FLAG_BIT]),
      .count(cnt[g]), .flag(flag_v[g]), .raise(raise_v[g])
    );

    AST_ZERO_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_q[g-1][EVT_W-1:0] == '0) && !wr_ctr[g]) |=> $stable(cnt[g])); // R4
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inhibit_q <= '1;
      ovf_q     <= '0;
      for (int n = 0; n < NUM_EVT; n++) sel_q[n] <= '0;
    end else begin
      if (wr_inh) inhibit_q <= reg_wdata[NUM_CTR-1:0];
      ovf_q <= (ovf_q & ~ovf_clr) | raise_v;
      for (int n = 0; n < NUM_EVT; n++)
        if (wr_sel[n]) sel_q[n] <= reg_wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(INH_OFS)) reg_rdata = 64'(inhibit_q);
    if (reg_addr == ADDR_W'(OVF_OFS)) reg_rdata = 64'(ovf_q);
    for (int n = 0; n < NUM_CTR; n++)
      if (reg_addr == ctr_addr(n))
        reg_rdata = {(n == 0) ? flag_v[0] : 1'b0, (63-CTR_W)'(0), cnt[n]};
    for (int n = 1; n < NUM_CTR; n++)
      if (reg_addr == sel_addr(n)) reg_rdata = {flag_v[n], sel_q[n-1]};
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ovf |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R10
endmodule

// File: tb/perf_ctr_bank_bench.sv
module perf_ctr_bank_bench;
  localparam int NUM_EVT = 7;
  localparam int CTR_W = 40;
  localparam int NUM_SRC = 2;
  localparam int ADDR_W = 12;
  localparam logic [63:0] MAXV = 64'h0000_00FF_FFFF_FFFF;
  localparam logic [ADDR_W-1:0] A_INH = 12'h058, A_OVF = 12'h060;
  localparam logic [ADDR_W-1:0] A_C0 = 12'h068, A_C1 = 12'h070;
  localparam logic [ADDR_W-1:0] A_S1 = 12'h160, A_S2 = 12'h168;

  typedef struct packed {
    logic [14:0] sid; logic pm, pv, dv, idt; logic [19:0] spid; logic [23:0] sdid;
    logic [14:0] eid; logic [19:0] epid; logic [23:0] edid; logic etyp;
    logic [63:0] expc; logic [3:0] req;
  } vec_t;

  // sid pm pv dv idt spid sdid | eid epid edid typ | expected req
  localparam vec_t VECS [14] = '{
    '{15'd3, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 24'h0, 15'd3, 20'h0, 24'h0, 1'b0, 64'd1, 4'd4},
    '{15'd3, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 24'h0, 15'd4, 20'h0, 24'h0, 1'b0, 64'd0, 4'd4},
    '{15'd0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 24'h0, 15'd0, 20'h0, 24'h0, 1'b0, 64'd0, 4'd4},
    '{15'd2, 1'b0, 1'b1, 1'b0, 1'b0, 20'h12345, 24'h0, 15'd2, 20'h12345, 24'h0, 1'b0, 64'd1, 4'd5},
    '{15'd2, 1'b0, 1'b1, 1'b0, 1'b0, 20'h12345, 24'h0, 15'd2, 20'h12346, 24'h0, 1'b0, 64'd0, 4'd5},
    '{15'd2, 1'b0, 1'b1, 1'b0, 1'b1, 20'h12345, 24'h0, 15'd2, 20'h12345, 24'h0, 1'b0, 64'd0, 4'd5},
    '{15'd5, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0, 24'hABCDE0, 15'd5, 20'h0, 24'hABCDE0, 1'b0, 64'd1, 4'd6},
    '{15'd5, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0, 24'hABCDE0, 15'd5, 20'h0, 24'hABCDE1, 1'b0, 64'd0, 4'd6},
    '{15'd5, 1'b1, 1'b0, 1'b1, 1'b0, 20'h0, 24'h00000B, 15'd5, 20'h0, 24'h00000C, 1'b0, 64'd1, 4'd6},
    '{15'd5, 1'b1, 1'b0, 1'b1, 1'b0, 20'h0, 24'h00000B, 15'd5, 20'h0, 24'h000013, 1'b0, 64'd0, 4'd6},
    '{15'd5, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0, 24'h00000B, 15'd5, 20'h0, 24'h00000C, 1'b0, 64'd0, 4'd6},
    '{15'd7, 1'b0, 1'b1, 1'b1, 1'b1, 20'h0ABCD, 24'h123456, 15'd7, 20'h0ABCD, 24'h123456, 1'b1, 64'd1, 4'd5},
    '{15'd7, 1'b0, 1'b1, 1'b1, 1'b1, 20'h0ABCD, 24'h123456, 15'd7, 20'h0ABCD, 24'h123457, 1'b1, 64'd0, 4'd6},
    '{15'd8, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00001, 24'h0, 15'd8, 20'h00002, 24'h0, 1'b0, 64'd1, 4'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [NUM_SRC-1:0] evt_valid = '0;
  logic [NUM_SRC*15-1:0] evt_id = '0;
  logic [NUM_SRC*20-1:0] evt_pid = '0;
  logic [NUM_SRC*24-1:0] evt_did = '0;
  logic [NUM_SRC-1:0] evt_idtype = '0;
  logic ovf_irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  perf_ctr_bank #(.NUM_EVT(NUM_EVT), .CTR_W(CTR_W), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_perf_ctr_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_valid(evt_valid), .evt_id(evt_id), .evt_pid(evt_pid),
    .evt_did(evt_did), .evt_idtype(evt_idtype), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_lanes(input logic [NUM_SRC-1:0] v, input logic [14:0] id,
                           input logic [19:0] pid, input logic [23:0] did, input logic typ);
    evt_valid = v; evt_id = {NUM_SRC{id}}; evt_pid = {NUM_SRC{pid}};
    evt_did = {NUM_SRC{did}}; evt_idtype = {NUM_SRC{typ}};
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] v, input logic [14:0] id,
                       input logic [19:0] pid, input logic [23:0] did, input logic typ);
    @(negedge clk);
    set_lanes(v, id, pid, did, typ);
    @(negedge clk);
    evt_valid = '0;
  endtask

  function automatic logic [63:0] mk_sel(input vec_t v);
    return {1'b0, v.idt, v.dv, v.pv, v.sdid, v.spid, v.pm, v.sid};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, counters held by the all-ones inhibit word
    rd(A_INH, d); chk("R1 inhibit after reset", d, 64'hFF);
    rd(A_C0, d);  chk("R1 cycle counter held", d, 64'h0);
    rd(A_OVF, d); chk("R1 status after reset", d, 64'h0);
    rd(A_S1, d);  chk("R1 selector after reset", d, 64'h0);
    chk("R1 irq after reset", 64'(ovf_irq), 64'h0);

    // R4 R5 R6: match table on counter 1
    wr(A_INH, 64'hFD);
    for (int i = 0; i < 14; i++) begin
      wr(A_S1, mk_sel(VECS[i]));
      wr(A_C1, 64'h0);
      pulse(2'b01, VECS[i].eid, VECS[i].epid, VECS[i].edid, VECS[i].etyp);
      rd(A_C1, d);
      chk($sformatf("R%0d match vector %0d", VECS[i].req, i), d, VECS[i].expc);
    end

    // R4: both lanes hit in one clock
    wr(A_S1, 64'd3);
    wr(A_C1, 64'h0);
    pulse(2'b11, 15'd3, 20'h0, 24'h0, 1'b0);
    rd(A_C1, d); chk("R4 two lanes same clock", d, 64'd2);

    // R12: write wins over a same-clock increment
    @(negedge clk);
    set_lanes(2'b01, 15'd3, 20'h0, 24'h0, 1'b0);
    reg_wr_en = 1'b1; reg_addr = A_C1; reg_wdata = 64'h55;
    @(negedge clk);
    reg_wr_en = 1'b0; evt_valid = '0;
    rd(A_C1, d); chk("R12 write beats increment", d, 64'h55);

    // R7: inhibited event counter ignores a matching strobe
    wr(A_INH, 64'hFF);
    pulse(2'b11, 15'd3, 20'h0, 24'h0, 1'b0);
    rd(A_C1, d); chk("R7 inhibited event counter", d, 64'h55);

    // R8: width truncation; R2 map
    wr(A_C1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_C1, d); chk("R8 counter width", d, MAXV);
    wr(A_S2, 64'h1234_5678_9ABC_DEF0);
    rd(A_S2, d); chk("R2 selector 2 readback", d, 64'h1234_5678_9ABC_DEF0);
    rd(12'h300, d); chk("R2 unmapped reads zero", d, 64'h0);
    wr(A_INH, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_INH, d); chk("R7 inhibit upper bits", d, 64'hFF);

    // R3: cycle counting
    wr(A_INH, 64'hFC);
    wr(A_C0, 64'h0);
    repeat (5) @(negedge clk);
    rd(A_C0, d); chk("R3 cycle count after 5 clocks", d, 64'd5);
    wr(A_INH, 64'hFD);
    rd(A_C0, v);
    repeat (3) @(negedge clk);
    rd(A_C0, d); chk("R7 cycle counter frozen", d, v);

    // R9 R10: cycle wrap with flag clear
    wr(A_C0, MAXV - 64'd1);
    wr(A_INH, 64'hFC);
    repeat (2) @(negedge clk);
    rd(A_C0, d); chk("R9 cycle wrap sets flag", d, 64'h8000_0000_0000_0000);
    rd(A_OVF, d); chk("R10 status bit 0 on wrap", d, 64'h1);
    chk("R10 irq on wrap", 64'(ovf_irq), 64'h1);
    wr(A_INH, 64'hFD);
    wr(A_OVF, 64'h1);
    chk("R10 irq cleared by write-one", 64'(ovf_irq), 64'h0);

    // R11: wrap with flag still set stays silent
    wr(A_C0, 64'h8000_0000_0000_0000 | (MAXV - 64'd1));
    wr(A_INH, 64'hFC);
    repeat (2) @(negedge clk);
    rd(A_OVF, d); chk("R11 no status with flag set", d, 64'h0);
    chk("R11 no irq with flag set", 64'(ovf_irq), 64'h0);
    wr(A_INH, 64'hFD);
    wr(A_C0, MAXV - 64'd1);
    wr(A_INH, 64'hFC);
    repeat (2) @(negedge clk);
    rd(A_OVF, d); chk("R11 re-armed after flag clear", d, 64'h1);
    wr(A_INH, 64'hFD);
    wr(A_OVF, 64'hFF);

    // R9 R10: event counter wrap sets selector flag
    wr(A_S1, 64'd3);
    wr(A_C1, MAXV);
    pulse(2'b01, 15'd3, 20'h0, 24'h0, 1'b0);
    rd(A_C1, d); chk("R9 event counter wraps", d, 64'h0);
    rd(A_S1, d); chk("R9 selector flag set", d, 64'h8000_0000_0000_0003);
    rd(A_OVF, d); chk("R10 status bit 1", d, 64'h2);
    chk("R10 irq from event wrap", 64'(ovf_irq), 64'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule